// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sets the length of every bus cycle the processor runs. The external memory space is split into eight areas. Each area has its own timing profile, made of two settings. The first is a speed bit that picks 2-state or 3-state timing. The second is a 3-bit count of program wait states, which is added only when the area uses 3-state timing. All of these settings sit in three registers, which are read and written through a small register port. The read path is combinational.

For each access the requester presents an area number and a flag that says whether the target is on-chip. The controller accepts the request when it is idle. It then latches the cycle length at once, holds `acc_busy` high for that many clock cycles, and pulses `acc_done` in the final one. On-chip targets always take two states, whatever the settings. A hardware standby input puts every register back to its power-on value and abandons any cycle in progress. Only a write, a reset or a hardware standby changes the registers.

Top module: `ext_wait_ctrl`

## Requirements
- R1: The register port decodes `reg_addr` as follows. Address 0 reads the speed bits in bits 7..0, and bits 15..8 read zero. Address 1 holds the wait counts of areas 0..3 and address 2 holds those of areas 4..7. Area n sits in nibble (n mod 4), with its count in bits 4*(n mod 4)+2 down to 4*(n mod 4). Address 3 reads zero and ignores writes.
- R2: Bit 3 of every nibble at addresses 1 and 2 reads 0, and a write to it has no effect.
- R3: After `rst_n` is asserted, address 0 reads 0x00FF and addresses 1 and 2 each read 0x7777. `acc_busy` and `acc_done` are low.
- R4: A cycle with `hw_standby` high restores the values of R3 and ends any access, so `acc_busy` is low in the next cycle. A register write made in that same cycle is ignored.
- R5: An access with `acc_onchip`=1 lasts 2 cycles. This holds whatever the speed bits and wait counts are.
- R6: An external access to an area whose speed bit is 0 lasts 2 cycles. The area's wait count is ignored.
- R7: An external access to an area whose speed bit is 1 lasts 3+W cycles, where W is that area's 3-bit wait count.
- R8: A request is accepted at a rising edge where `acc_req`=1 and `acc_busy`=0. `acc_busy` is then high for exactly the access length. `acc_done` is high only in the last of those cycles and lasts one cycle.
- R9: `acc_req` is ignored while `acc_busy` is high. Holding it high through an access neither lengthens that access nor starts another one right after it.
- R10: A register write made during an access leaves that access's length unchanged. It applies from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| hw_standby | input | 1 | Hardware standby: restores register defaults and aborts the access |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| acc_req | input | 1 | Access request, level |
| acc_area | input | 3 | Target area of the request |
| acc_onchip | input | 1 | Target is on-chip memory or an internal register |
| acc_busy | output | 1 | Access cycle in progress |
| acc_done | output | 1 | Final state of the access |

## Verification
The bench builds the block with its default parameters: eight areas and 3-bit wait counts. With these settings both wait registers are in use and the longest access takes ten cycles. Random register contents and random targets cover the whole range of wait counts. They also mix the speed-bit settings with on-chip accesses in many combinations. Directed cases cover five things: the zero and maximum counts, the padding bits, a request held high through an access, a write in the middle of an access, and hardware standby arriving during an access.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   localparam int REG_DATA_W     = 16;
   localparam int AREAS_PER_WREG = 4;
   localparam int FIELD_STRIDE   = 4;
   localparam logic [REG_DATA_W-1:0] PAD_MASK = 16'h8888;

endpackage

// File: rtl/ewc_regfile.sv
module ewc_regfile
   import ewc_pkg::*;
#(
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 3,
   parameter int ADDR_W    = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hw_standby,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [REG_DATA_W-1:0]       wdata,
   output logic [REG_DATA_W-1:0]       rdata,
   output logic [NUM_AREAS-1:0]        ast_q,
   output logic [NUM_AREAS*WAIT_W-1:0] wait_flat
);

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;

   // speed bits: one per area
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ast_q <= '1;
      else if (hw_standby)
         ast_q <= '1;
      else if (wr_en && addr == ADDR_W'(0))
         ast_q <= wdata[NUM_AREAS-1:0];
   end

   // per-area wait counts
   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
      localparam int WIDX = g / AREAS_PER_WREG;
      localparam int SLOT = g % AREAS_PER_WREG;
      logic [WAIT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '1;
         else if (hw_standby)
            cnt_q <= '1;
         else if (wr_en && addr == ADDR_W'(1 + WIDX))
            cnt_q <= wdata[SLOT*FIELD_STRIDE +: WAIT_W];
      end

      assign wait_flat[g*WAIT_W +: WAIT_W] = cnt_q;
   end

   // read mux
   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(0))
         rdata[NUM_AREAS-1:0] = ast_q;
      for (int g = 0; g < NUM_AREAS; g++) begin
         if (addr == ADDR_W'(1 + g / AREAS_PER_WREG))
            rdata[(g % AREAS_PER_WREG)*FIELD_STRIDE +: WAIT_W] = wait_flat[g*WAIT_W +: WAIT_W];
      end
   end

endmodule

// File: rtl/ewc_len_sel.sv
module ewc_len_sel #(
   parameter int NUM_AREAS = 8,
   parameter int WAIT_W    = 3,
   parameter int AREA_W    = 3,
   parameter int CNT_W     = 4
) (
   input  logic [AREA_W-1:0]           area,
   input  logic                        onchip,
   input  logic [NUM_AREAS-1:0]        ast_q,
   input  logic [NUM_AREAS*WAIT_W-1:0] wait_flat,
   output logic [CNT_W-1:0]            len_m1
);

   logic [WAIT_W-1:0] w_sel;

   always_comb begin
      w_sel = '0;
      for (int g = 0; g < NUM_AREAS; g++) begin
         if (area == AREA_W'(g))
            w_sel = wait_flat[g*WAIT_W +: WAIT_W];
      end
   end

   // length minus one: 1 for two-state cycles, 2+W for three-state ones
   always_comb begin
      if (onchip || !ast_q[area])
         len_m1 = CNT_W'(1);
      else
         len_m1 = CNT_W'(2) + CNT_W'(w_sel);
   end

endmodule

// File: rtl/ewc_seq.sv
module ewc_seq
   import ewc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_standby,
   input  logic             req,
   input  logic [CNT_W-1:0] len_m1,
   output logic             busy,
   output logic             done
);

   seq_state_e       state_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         left_q  <= '0;
      end else if (hw_standby) begin
         state_q <= SEQ_IDLE;
         left_q  <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (req) begin
                  state_q <= SEQ_RUN;
                  left_q  <= len_m1;
               end
            end
            SEQ_RUN: begin
               if (left_q == '0)
                  state_q <= SEQ_IDLE;
               else
                  left_q <= left_q - CNT_W'(1);
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy = (state_q == SEQ_RUN);
   assign done = busy && (left_q == '0);

endmodule

// File: rtl/ext_wait_ctrl.sv
module ext_wait_ctrl
   import ewc_pkg::*;
#(
   parameter  int NUM_AREAS = 8,
   parameter  int WAIT_W    = 3,
   localparam int ADDR_W    = $clog2(NUM_AREAS / AREAS_PER_WREG + 1),
   localparam int AREA_W    = $clog2(NUM_AREAS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hw_standby,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [REG_DATA_W-1:0] reg_wdata,
   output logic [REG_DATA_W-1:0] reg_rdata,
   input  logic                  acc_req,
   input  logic [AREA_W-1:0]     acc_area,
   input  logic                  acc_onchip,
   output logic                  acc_busy,
   output logic                  acc_done
);

   localparam int CNT_W = $clog2(3 + (1 << WAIT_W));

   if (NUM_AREAS % AREAS_PER_WREG != 0 || NUM_AREAS < 4 || NUM_AREAS > REG_DATA_W) begin : g_bad_areas
      $error("NUM_AREAS must be 4, 8, 12 or 16");
   end
   if (WAIT_W < 1 || WAIT_W >= FIELD_STRIDE) begin : g_bad_wait
      $error("WAIT_W must be between 1 and 3");
   end

   logic [NUM_AREAS-1:0]        ast_q;
   logic [NUM_AREAS*WAIT_W-1:0] wait_flat;
   logic [CNT_W-1:0]            len_m1;

   ewc_regfile #(
      .NUM_AREAS(NUM_AREAS),
      .WAIT_W   (WAIT_W),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_standby(hw_standby),
      .wr_en     (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .rdata     (reg_rdata),
      .ast_q     (ast_q),
      .wait_flat (wait_flat)
   );

   ewc_len_sel #(
      .NUM_AREAS(NUM_AREAS),
      .WAIT_W   (WAIT_W),
      .AREA_W   (AREA_W),
      .CNT_W    (CNT_W)
   ) u_len (
      .area     (acc_area),
      .onchip   (acc_onchip),
      .ast_q    (ast_q),
      .wait_flat(wait_flat),
      .len_m1   (len_m1)
   );

   ewc_seq #(
      .CNT_W(CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_standby(hw_standby),
      .req       (acc_req),
      .len_m1    (len_m1),
      .busy      (acc_busy),
      .done      (acc_done)
   );

endmodule

// File: rtl/ewc_checker.sv
module ewc_checker
   import ewc_pkg::*;
#(
   parameter  int NUM_AREAS = 8,
   parameter  int WAIT_W    = 3,
   localparam int ADDR_W    = $clog2(NUM_AREAS / AREAS_PER_WREG + 1),
   localparam int AREA_W    = $clog2(NUM_AREAS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        hw_standby,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic [REG_DATA_W-1:0]       reg_rdata,
   input logic                        acc_req,
   input logic [AREA_W-1:0]           acc_area,
   input logic                        acc_onchip,
   input logic                        acc_busy,
   input logic                        acc_done,
   input logic [NUM_AREAS-1:0]        ast_q,
   input logic [NUM_AREAS*WAIT_W-1:0] wait_flat
);

   assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |-> acc_busy);

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
      acc_done |=> !acc_done);

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
      (!acc_busy && acc_req) |=> acc_busy);

   assert_onchip_two_R5: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
      (!acc_busy && acc_req && acc_onchip) |=> (!acc_done ##1 acc_done));

   assert_short_area_R6: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
      (!acc_busy && acc_req && !acc_onchip && !ast_q[acc_area]) |=> (!acc_done ##1 acc_done));

   assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n || hw_standby)
      acc_done |=> !acc_busy);

   assert_standby_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hw_standby |=> (ast_q == '1 && wait_flat == '1 && !acc_busy));

   assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr != ADDR_W'(0)) |-> ((reg_rdata & PAD_MASK) == '0));

endmodule

bind ext_wait_ctrl ewc_checker #(
   .NUM_AREAS(NUM_AREAS),
   .WAIT_W   (WAIT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hw_standby(hw_standby),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .acc_req   (acc_req),
   .acc_area  (acc_area),
   .acc_onchip(acc_onchip),
   .acc_busy  (acc_busy),
   .acc_done  (acc_done),
   .ast_q     (ast_q),
   .wait_flat (wait_flat)
);

// File: tb/ext_wait_ctrl_bench.sv
module ext_wait_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hw_standby = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        acc_req = 1'b0;
   logic [2:0]  acc_area = '0;
   logic        acc_onchip = 1'b0;
   logic        acc_busy;
   logic        acc_done;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   logic [7:0] ast_m;
   logic [2:0] wait_m [8];

   always #5 clk = ~clk;

   ext_wait_ctrl u_ext_wait_ctrl (
      .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acc_req(acc_req), .acc_area(acc_area), .acc_onchip(acc_onchip),
      .acc_busy(acc_busy), .acc_done(acc_done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic void model_reset();
      ast_m = 8'hFF;
      for (int i = 0; i < 8; i++) wait_m[i] = 3'd7;
   endfunction

   function automatic void model_write(input logic [1:0] a, input logic [15:0] d);
      if (a == 2'd0) ast_m = d[7:0];
      else if (a == 2'd1) for (int i = 0; i < 4; i++) wait_m[i] = d[4*i +: 3];
      else if (a == 2'd2) for (int i = 0; i < 4; i++) wait_m[4+i] = d[4*i +: 3];
   endfunction

   function automatic logic [15:0] model_read(input logic [1:0] a);
      logic [15:0] r = '0;
      if (a == 2'd0) r[7:0] = ast_m;
      else if (a == 2'd1) for (int i = 0; i < 4; i++) r[4*i +: 3] = wait_m[i];
      else if (a == 2'd2) for (int i = 0; i < 4; i++) r[4*i +: 3] = wait_m[4+i];
      return r;
   endfunction

   function automatic int exp_len(input int area, input bit onchip);
      if (onchip || !ast_m[area]) return 2;
      return 3 + int'(wait_m[area]);
   endfunction

   task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic read_all(input string tag);
      for (int a = 0; a < 4; a++) begin
         reg_addr = 2'(a);
         #1;
         check(reg_rdata === model_read(2'(a)), tag, int'(reg_rdata), int'(model_read(2'(a))));
      end
   endtask

   task automatic run_access(input int area, input bit onchip, input bit hold,
                             input bit mid, input logic [1:0] ma, input logic [15:0] md,
                             input string tag);
      int exp, n;
      bit busy_ok;
      exp = exp_len(area, onchip);
      @(negedge clk);
      acc_area = 3'(area); acc_onchip = onchip; acc_req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      if (!hold) acc_req = 1'b0;
      if (mid) begin reg_wr = 1'b1; reg_addr = ma; reg_wdata = md; end
      n = 1;
      busy_ok = 1'b1;
      while (!acc_done && n < 40) begin
         if (!acc_busy) busy_ok = 1'b0;
         @(negedge clk);
         reg_wr = 1'b0;
         n++;
      end
      acc_req = 1'b0;
      reg_wr = 1'b0;
      check(n == exp, tag, n, exp);
      check(busy_ok && acc_busy, {tag, " busy during access (R8)"}, int'(busy_ok), 1);
      @(negedge clk);
      check(!acc_busy && !acc_done, {tag, " idle after done (R8/R9)"}, int'(acc_busy), 0);
      if (mid) model_write(ma, md);
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
         end
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      model_reset();
      #12;
      // R3 reset state
      check(acc_busy === 1'b0 && acc_done === 1'b0, "R3 outputs in reset", int'(acc_busy), 0);
      read_all("R3 reset values");
      @(negedge clk);
      rst_n = 1'b1;

      // R5 on-chip with defaults
      run_access(3, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, "R5 onchip len");
      // R7 default W=7 -> 10
      run_access(6, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R7 default len");
      // R6 speed bit 0 ignores W=7
      reg_write(2'd0, 16'h00DF);
      run_access(5, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R6 two-state len");
      run_access(5, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, "R5 onchip two-state area");
      reg_write(2'd0, 16'h00FF);
      // R7 various counts, R1 field placement
      reg_write(2'd1, 16'h3210);
      reg_write(2'd2, 16'h7000);
      read_all("R1 map readback");
      run_access(0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R7 W=0 len");
      run_access(2, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R7 W=2 len");
      run_access(3, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R7 W=3 len");
      run_access(7, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R7 W=7 len");
      run_access(4, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R7 W=0 high reg len");
      // R2 pad bits
      reg_write(2'd1, 16'hFFFF);
      reg_write(2'd2, 16'h8888);
      read_all("R2 pad bits");
      // R1 address 3 ignored
      reg_write(2'd3, 16'h1234);
      read_all("R1 unused address");
      // R9 request held high
      run_access(1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0, "R9 held req len");
      run_access(2, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0, "R9 held req onchip len");
      // R10 write mid access: area 1 W=7 -> 10, then W=0 -> 3
      run_access(1, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0000, "R10 current access len");
      run_access(1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R10 next access len");
      run_access(5, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0000, "R10 speed change current");
      run_access(5, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, "R10 speed change next");

      // R4 hardware standby during an access, with a write in the same cycle
      reg_write(2'd0, 16'h00FF);
      reg_write(2'd2, 16'h1111);
      @(negedge clk);
      acc_area = 3'd6; acc_onchip = 1'b0; acc_req = 1'b1;
      @(negedge clk);
      acc_req = 1'b0;
      @(negedge clk);
      hw_standby = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000;
      @(negedge clk);
      hw_standby = 1'b0; reg_wr = 1'b0;
      check(!acc_busy, "R4 access aborted", int'(acc_busy), 0);
      model_reset();
      read_all("R4 standby restores defaults");

      // random phase
      for (int it = 0; it < 80; it++) begin
         int kind = int'($urandom_range(0, 2));
         if (kind == 0) begin
            reg_write(2'($urandom_range(0, 3)), 16'($urandom));
            read_all("R1 random readback");
         end else begin
            int ar = int'($urandom_range(0, 7));
            bit oc = ($urandom_range(0, 3) == 0);
            bit hd = ($urandom_range(0, 1) == 1);
            string tg = oc ? "R5 random" : (ast_m[ar] ? "R7 random" : "R6 random");
            run_access(ar, oc, hd, 1'b0, 2'd0, 16'h0, tg);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule